// File: doc/BRIEF.md
# Half-Bridge Power Stage Protection Controller

This block is the digital protection and fault-reporting logic for a power stage of four half-bridges, arranged as two pairs (A/B and C/D). It takes comparator-level fault indications and decides, for each half-bridge, whether its output FETs must be held in high impedance and whether a weak output pulldown is switched on. It also drives two active-low status flags toward a system controller: one for shutdown and one for overtemperature warning. Current sensing, temperature sensing, gate drive and threshold setting sit outside. They reach the block as per-half-bridge current-limit flags, a direct overload trip per pair, supply undervoltage flags, a power-on-reset flag and a sampled junction temperature code in degrees Celsius.

Faults have three scopes. A pair's overload takes only that pair offline and stays latched until the pair's reset pin returns high. The overtemperature error is global and latched, and needs both pair resets low on a cooled die before it clears. Undervoltage and power-on reset are global and are not latched. A persistent overcurrent first only limits current. It becomes a latched overload once limiting has been active for a set number of consecutive PWM frames. Three mode pins select the output configuration, and the configuration decides whether the weak pulldowns run while a pair is held in reset.

Top module: `pstage_guard`

## Requirements
- R1: Mode pins decode as 000 two-line BTL, 010 one-line BTL, 011 one-line parallel BTL, 100 one-line single-ended. The codes 001, 101, 110 and 111 are reserved. A reserved code holds all four half-bridges in Hi-Z with every pulldown off, and it does not pull the shutdown flag low.
- R2: Half-bridges 0 and 1 (A, B) form pair 0, and half-bridges 2 and 3 (C, D) form pair 1. Outside parallel mode, a latched overload on a pair puts only that pair's two half-bridges in Hi-Z (hiz_o bits [1:0] for pair 0, bits [3:2] for pair 1).
- R3: In parallel BTL mode (011), a latched overload on either pair puts all four half-bridges in Hi-Z.
- R4: An overload trips on a half-bridge when its current-limit flag is high at OLP_FRAMES consecutive frame strobes. A strobe with the flag low restarts the count, and OLP_FRAMES-1 strobes do not trip.
- R5: A high direct overload input for a pair latches that pair's overload without waiting for frames.
- R6: A latched overload stays set after its cause is gone. It clears only on a low-to-high return of that pair's own reset pin, or on power-on reset. The other pair's reset does not clear it.
- R7: Any undervoltage flag, or power-on reset, puts all four half-bridges in Hi-Z. The outputs reflect an input change on the second rising clock edge after the change, through two-flop synchronisers.
- R8: Undervoltage is not latched. Once every undervoltage flag is low, the outputs return to normal operation with no reset.
- R9: A temperature at or above ERR_C (default 155) latches an overtemperature error, which puts all half-bridges in Hi-Z. The error clears only while both pair resets are low and the temperature is below ERR_C-ERR_HYST (default 125). One reset low, or a hot die, leaves it set.
- R10: The warning sets at or above WARN_C (default 125) and releases only below WARN_C-WARN_HYST (default 100). Between the two points it holds its previous state.
- R11: Status encoding: sd_n_o is low when an overload, overtemperature error or undervoltage is present. otw_n_o is low when the warning or the overtemperature error is present. Both high means normal operation.
- R12: While either pair reset is low, sd_n_o is high whatever faults exist, and the half-bridges of a pair whose reset is low are in Hi-Z.
- R13: pd_en_o is high for the half-bridges of a pair whose reset is low, in modes 000, 010 and 011 only. It is low in single-ended mode 100, in reserved modes, and when the pair's reset is high.
- R14: A power-on reset pulse clears latched overloads and a latched overtemperature error. Once it ends, a cool, fault-free stage returns to normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset of the logic |
| frame_tick_i | input | 1 | One-cycle strobe per PWM frame, synchronous to clk |
| ilim_i | input | 4 | Current-limit active flag per half-bridge (asynchronous) |
| olp_i | input | 2 | Direct overload trip per pair (asynchronous) |
| uv_i | input | NSUP | Undervoltage flag per monitored supply (asynchronous) |
| por_i | input | 1 | Power-on-reset flag, active high (asynchronous) |
| temp_i | input | TW | Junction temperature code in degrees Celsius |
| rst_ab_n_i | input | 1 | Active-low reset for pair A/B |
| rst_cd_n_i | input | 1 | Active-low reset for pair C/D |
| mode_i | input | 3 | Output configuration select |
| hiz_o | output | 4 | Hi-Z enable per half-bridge |
| pd_en_o | output | 4 | Weak output pulldown enable per half-bridge |
| sd_n_o | output | 1 | Shutdown flag, active low |
| otw_n_o | output | 1 | Overtemperature warning flag, active low |

## Verification
The hardest states to reach are the latched ones reached through history: an overload that only trips after an unbroken run of limited frames, and an overtemperature error that must survive one pair reset and a hot-die double reset before it clears on a cooled double reset. The stimulus builds a run that is one frame short, then breaks it with a single clean frame, then completes it. It walks the temperature up through both thresholds and back down through both hysteresis bands, and toggles each pair reset on its own and both together. The result is read on the flags and Hi-Z outputs after each step.

// File: rtl/pstage_pkg.sv
// Package pstage_pkg
// Shared sizes, the output configuration encoding and its decoder.
// Assumes the stage always has two pairs of two half-bridges.
package pstage_pkg;

    localparam int NPAIR = 2;
    localparam int NHB   = 2 * NPAIR;

    typedef enum logic [2:0] {
        MD_BTL_2L = 3'b000,
        MD_RSV_1  = 3'b001,
        MD_BTL_1L = 3'b010,
        MD_PAR_1L = 3'b011,
        MD_SE_1L  = 3'b100,
        MD_RSV_5  = 3'b101,
        MD_RSV_6  = 3'b110,
        MD_RSV_7  = 3'b111
    } out_mode_e;

    typedef struct packed {
        logic reserved;   // code is not a legal configuration
        logic bridged;    // bridged load: pulldowns allowed during reset
        logic parallel;   // both pairs drive one load
    } mode_cfg_t;

    // Turn raw mode pins into configuration attributes
    function automatic mode_cfg_t decode_mode(input logic [2:0] code);
        mode_cfg_t cfg;
        cfg = '{reserved: 1'b1, bridged: 1'b0, parallel: 1'b0};
        case (out_mode_e'(code))
            MD_BTL_2L: cfg = '{reserved: 1'b0, bridged: 1'b1, parallel: 1'b0};
            MD_BTL_1L: cfg = '{reserved: 1'b0, bridged: 1'b1, parallel: 1'b0};
            MD_PAR_1L: cfg = '{reserved: 1'b0, bridged: 1'b1, parallel: 1'b1};
            MD_SE_1L:  cfg = '{reserved: 1'b0, bridged: 1'b0, parallel: 1'b0};
            default:   cfg = '{reserved: 1'b1, bridged: 1'b0, parallel: 1'b0};
        endcase
        return cfg;
    endfunction

endpackage

// File: rtl/pg_sync.sv
// Module pg_sync
// Two-flop synchroniser for a bundle of slowly changing asynchronous
// level signals. Assumes each bit is stable for several clocks, so
// bundle skew of one cycle is harmless. Resets to zero.
module pg_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Capture and re-time the bundle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/pg_olp_count.sv
// Module pg_olp_count
// Counts consecutive PWM frames with current limiting on one
// half-bridge and flags a trip on the FRAMES-th such frame.
// Assumes tick is a one-cycle strobe and ilim is already synchronous.
module pg_olp_count #(
    parameter int FRAMES = 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic tick,
    input  logic ilim,
    output logic trip
);
    localparam int CW = $clog2(FRAMES + 1);
    localparam logic [CW-1:0] LAST = CW'(FRAMES - 1);

    logic [CW-1:0] run_cnt;

    // Trip when this strobe completes the run
    assign trip = tick && ilim && !hold && (run_cnt == LAST);

    // Track the length of the current run of limited frames
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (hold) begin
            run_cnt <= '0;
        end else if (tick) begin
            if (!ilim)
                run_cnt <= '0;
            else if (run_cnt != LAST)
                run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pg_thermal.sv
// Module pg_thermal
// Warning flag with hysteresis and latched overtemperature error.
// The error clears only when clr_ok (both pair resets low) holds and
// the die is below the error release point. Assumes temp is synchronous.
module pg_thermal #(
    parameter int TW        = 8,
    parameter int WARN_C    = 125,
    parameter int WARN_HYST = 25,
    parameter int ERR_C     = 155,
    parameter int ERR_HYST  = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          por,
    input  logic          clr_ok,
    input  logic [TW-1:0] temp,
    output logic          warn,
    output logic          ote
);
    localparam logic [TW-1:0] WARN_SET = TW'(WARN_C);
    localparam logic [TW-1:0] WARN_REL = TW'(WARN_C - WARN_HYST);
    localparam logic [TW-1:0] ERR_SET  = TW'(ERR_C);
    localparam logic [TW-1:0] ERR_REL  = TW'(ERR_C - ERR_HYST);

    // Warning: set at threshold, release below hysteresis point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn <= 1'b0;
        end else if (temp >= WARN_SET) begin
            warn <= 1'b1;
        end else if (temp < WARN_REL) begin
            warn <= 1'b0;
        end
    end

    // Error latch: set when hot, clear on double reset once cooled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ote <= 1'b0;
        end else if (por) begin
            ote <= 1'b0;
        end else if (temp >= ERR_SET) begin
            ote <= 1'b1;
        end else if (clr_ok && (temp < ERR_REL)) begin
            ote <= 1'b0;
        end
    end
endmodule

// File: rtl/pstage_guard.sv
// Module pstage_guard
// Protection controller for four half-bridges in two pairs. Combines
// pair-scoped overload latches, a global overtemperature latch and
// global undervoltage / power-on-reset faults into Hi-Z and pulldown
// controls plus active-low shutdown and warning flags.
// Assumes frame_tick_i is synchronous; all other inputs may be async.
module pstage_guard
    import pstage_pkg::*;
#(
    parameter int NSUP       = 5,
    parameter int TW         = 8,
    parameter int OLP_FRAMES = 480,
    parameter int WARN_C     = 125,
    parameter int WARN_HYST  = 25,
    parameter int ERR_C      = 155,
    parameter int ERR_HYST   = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_tick_i,
    input  logic [3:0]      ilim_i,
    input  logic [1:0]      olp_i,
    input  logic [NSUP-1:0] uv_i,
    input  logic            por_i,
    input  logic [TW-1:0]   temp_i,
    input  logic            rst_ab_n_i,
    input  logic            rst_cd_n_i,
    input  logic [2:0]      mode_i,
    output logic [3:0]      hiz_o,
    output logic [3:0]      pd_en_o,
    output logic            sd_n_o,
    output logic            otw_n_o
);
    localparam int SW = NHB + NPAIR + NSUP + 1 + NPAIR + 3;

    logic [SW-1:0]    raw_bus, sync_bus;
    logic [NHB-1:0]   ilim_s;
    logic [NPAIR-1:0] olp_s;
    logic [NSUP-1:0]  uv_s;
    logic             por_s;
    logic [NPAIR-1:0] rst_s, rst_d, rst_rise;
    logic [2:0]       mode_s;
    logic [TW-1:0]    temp_s;
    logic             uv_any, glb_fault;
    mode_cfg_t        cfg;
    logic [NHB-1:0]   hb_trip;
    logic [NPAIR-1:0] pair_set, ovl_q, ovl_eff, pair_hiz;
    logic             warn, ote;

    assign raw_bus = {ilim_i, olp_i, uv_i, por_i, rst_cd_n_i, rst_ab_n_i, mode_i};

    pg_sync #(.W(SW)) u_sync_flags (
        .clk(clk), .rst_n(rst_n), .d(raw_bus), .q(sync_bus)
    );

    pg_sync #(.W(TW)) u_sync_temp (
        .clk(clk), .rst_n(rst_n), .d(temp_i), .q(temp_s)
    );

    assign {ilim_s, olp_s, uv_s, por_s, rst_s, mode_s} = sync_bus;

    assign uv_any    = |uv_s;
    assign glb_fault = uv_any | por_s | ote;
    assign cfg       = decode_mode(mode_s);
    assign rst_rise  = rst_s & ~rst_d;

    // Delay the synchronised pair resets for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rst_d <= '0;
        else        rst_d <= rst_s;
    end

    // One persistence counter per half-bridge, held while its pair is inactive
    for (genvar h = 0; h < NHB; h++) begin : g_hb
        pg_olp_count #(.FRAMES(OLP_FRAMES)) u_olp_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .hold (!rst_s[h/2] || por_s || ovl_q[h/2]),
            .tick (frame_tick_i),
            .ilim (ilim_s[h]),
            .trip (hb_trip[h])
        );
    end

    // Per-pair overload latch: set wins over a same-cycle reset release
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign pair_set[p] = rst_s[p] && (olp_s[p] || hb_trip[2*p] || hb_trip[2*p+1]);

        // Hold the overload until the pair reset returns high
        always_ff @(posedge clk) begin
            if (!rst_n)           ovl_q[p] <= 1'b0;
            else if (por_s)       ovl_q[p] <= 1'b0;
            else if (pair_set[p]) ovl_q[p] <= 1'b1;
            else if (rst_rise[p]) ovl_q[p] <= 1'b0;
        end

        assign ovl_eff[p]  = cfg.parallel ? (|ovl_q) : ovl_q[p];
        assign pair_hiz[p] = !rst_s[p] || ovl_eff[p];
    end

    pg_thermal #(
        .TW(TW), .WARN_C(WARN_C), .WARN_HYST(WARN_HYST),
        .ERR_C(ERR_C), .ERR_HYST(ERR_HYST)
    ) u_thermal (
        .clk   (clk),
        .rst_n (rst_n),
        .por   (por_s),
        .clr_ok(rst_s == '0),
        .temp  (temp_s),
        .warn  (warn),
        .ote   (ote)
    );

    // Per-half-bridge output controls
    for (genvar h = 0; h < NHB; h++) begin : g_out
        assign hiz_o[h]   = cfg.reserved || glb_fault || pair_hiz[h/2];
        assign pd_en_o[h] = !rst_s[h/2] && cfg.bridged;
    end

    assign sd_n_o  = (rst_s != {NPAIR{1'b1}}) ? 1'b1 : !((|ovl_q) || ote || uv_any);
    assign otw_n_o = !(warn || ote);

endmodule

// File: rtl/pstage_guard_chk.sv
// Module pstage_guard_chk
// Temporal checks on the protection controller, attached by bind.
module pstage_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rst_s,
    input logic [1:0] rst_d,
    input logic       por_s,
    input logic       uv_any,
    input logic [2:0] mode_s,
    input logic [1:0] ovl_q,
    input logic       ote,
    input logic [3:0] hiz_o,
    input logic [3:0] pd_en_o,
    input logic       sd_n_o
);
    // R12
    sd_forced_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_s != 2'b11) |-> sd_n_o);

    // R7
    global_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (por_s || uv_any) |-> (hiz_o == 4'hF));

    // R1
    reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s inside {3'b001, 3'b101, 3'b110, 3'b111}) |-> (hiz_o == 4'hF && pd_en_o == 4'h0));

    // R13
    se_no_pulldown_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s == 3'b100) |-> (pd_en_o == 4'h0));

    // R6
    ovl0_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovl_q[0]) |-> ($past(por_s) || $past(rst_s[0] && !rst_d[0])));

    // R6
    ovl1_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovl_q[1]) |-> ($past(por_s) || $past(rst_s[1] && !rst_d[1])));

    // R9
    ote_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ote) |-> ($past(por_s) || $past(rst_s == 2'b00)));

    // R11
    sd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_n_o |-> ((|ovl_q) || ote || uv_any));
endmodule

bind pstage_guard pstage_guard_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_s  (rst_s),
    .rst_d  (rst_d),
    .por_s  (por_s),
    .uv_any (uv_any),
    .mode_s (mode_s),
    .ovl_q  (ovl_q),
    .ote    (ote),
    .hiz_o  (hiz_o),
    .pd_en_o(pd_en_o),
    .sd_n_o (sd_n_o)
);

// File: tb/pstage_guard_bench.sv
// Bench for pstage_guard: a vector table walk, then directed sequences.
module pstage_guard_bench;
    localparam int NSUP = 5;
    localparam int TW   = 8;
    localparam int FR   = 4;
    localparam int NVEC = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_tick_i = 1'b0;
    logic [3:0]      ilim_i = '0;
    logic [1:0]      olp_i = '0;
    logic [NSUP-1:0] uv_i = '0;
    logic            por_i = 1'b0;
    logic [TW-1:0]   temp_i = 8'd25;
    logic            rst_ab_n_i = 1'b1;
    logic            rst_cd_n_i = 1'b1;
    logic [2:0]      mode_i = 3'b000;
    logic [3:0]      hiz_o, pd_en_o;
    logic            sd_n_o, otw_n_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pstage_guard #(.NSUP(NSUP), .TW(TW), .OLP_FRAMES(FR)) u_pstage_guard (
        .clk(clk), .rst_n(rst_n), .frame_tick_i(frame_tick_i),
        .ilim_i(ilim_i), .olp_i(olp_i), .uv_i(uv_i), .por_i(por_i),
        .temp_i(temp_i), .rst_ab_n_i(rst_ab_n_i), .rst_cd_n_i(rst_cd_n_i),
        .mode_i(mode_i), .hiz_o(hiz_o), .pd_en_o(pd_en_o),
        .sd_n_o(sd_n_o), .otw_n_o(otw_n_o)
    );

    // {mode, rst_ab, rst_cd, uv, exp_hiz, exp_pd, exp_sd}
    localparam logic [14:0] VEC [NVEC] = '{
        {3'b000, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b1},
        {3'b000, 1'b0, 1'b1, 1'b0, 4'b0011, 4'b0011, 1'b1},
        {3'b000, 1'b1, 1'b0, 1'b0, 4'b1100, 4'b1100, 1'b1},
        {3'b010, 1'b0, 1'b0, 1'b0, 4'b1111, 4'b1111, 1'b1},
        {3'b011, 1'b0, 1'b1, 1'b0, 4'b0011, 4'b0011, 1'b1},
        {3'b100, 1'b0, 1'b1, 1'b0, 4'b0011, 4'b0000, 1'b1},
        {3'b100, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b1},
        {3'b001, 1'b1, 1'b1, 1'b0, 4'b1111, 4'b0000, 1'b1},
        {3'b111, 1'b0, 1'b0, 1'b0, 4'b1111, 4'b0000, 1'b1},
        {3'b101, 1'b1, 1'b1, 1'b0, 4'b1111, 4'b0000, 1'b1},
        {3'b110, 1'b1, 1'b1, 1'b0, 4'b1111, 4'b0000, 1'b1},
        {3'b000, 1'b1, 1'b1, 1'b1, 4'b1111, 4'b0000, 1'b0},
        {3'b000, 1'b0, 1'b1, 1'b1, 4'b1111, 4'b0011, 1'b1},
        {3'b010, 1'b1, 1'b1, 1'b0, 4'b0000, 4'b0000, 1'b1}
    };

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        step(5);
    endtask

    task automatic check(input string req, input string what,
                         input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic check_out(input string req, input logic [3:0] hz,
                             input logic sd, input logic ow);
        check(req, "hiz_o", {4'h0, hiz_o}, {4'h0, hz});
        check(req, "sd_n_o", {7'h0, sd_n_o}, {7'h0, sd});
        check(req, "otw_n_o", {7'h0, otw_n_o}, {7'h0, ow});
    endtask

    task automatic tick();
        frame_tick_i = 1'b1;
        step(1);
        frame_tick_i = 1'b0;
        step(1);
    endtask

    task automatic pulse_ab();
        rst_ab_n_i = 1'b0; settle();
        rst_ab_n_i = 1'b1; settle();
    endtask

    task automatic pulse_cd();
        rst_cd_n_i = 1'b0; settle();
        rst_cd_n_i = 1'b1; settle();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        // Reset state: resets seen low, everything Hi-Z, flags high
        step(3);
        check_out("R12", 4'b1111, 1'b1, 1'b1);
        rst_n = 1'b1;
        settle();
        check_out("R12", 4'b0000, 1'b1, 1'b1);

        // Table walk: modes, pair resets, undervoltage
        for (int i = 0; i < NVEC; i++) begin
            mode_i     = VEC[i][14:12];
            rst_ab_n_i = VEC[i][11];
            rst_cd_n_i = VEC[i][10];
            uv_i       = VEC[i][9] ? 5'b00100 : 5'b00000;
            settle();
            check("R1", "hiz_o", {4'h0, hiz_o}, {4'h0, VEC[i][8:5]});
            check("R13", "pd_en_o", {4'h0, pd_en_o}, {4'h0, VEC[i][4:1]});
            check("R8", "sd_n_o", {7'h0, sd_n_o}, {7'h0, VEC[i][0]});
        end
        mode_i = 3'b000; rst_ab_n_i = 1'b1; rst_cd_n_i = 1'b1; uv_i = '0;
        settle();

        // R7 latency: Hi-Z on the second edge after the change
        uv_i = 5'b10000;
        step(1);
        check("R7", "hiz_o one edge", {4'h0, hiz_o}, 8'h00);
        step(1);
        check("R7", "hiz_o two edges", {4'h0, hiz_o}, 8'h0F);
        uv_i = '0;
        settle();
        check_out("R8", 4'b0000, 1'b1, 1'b1);

        // R4 persistence: broken run does not trip, full run does
        ilim_i = 4'b0001;
        settle();
        repeat (FR - 1) tick();
        check_out("R4", 4'b0000, 1'b1, 1'b1);
        ilim_i = 4'b0000; settle();
        tick();
        ilim_i = 4'b0001; settle();
        repeat (FR - 1) tick();
        check_out("R4", 4'b0000, 1'b1, 1'b1);
        tick();
        step(2);
        check_out("R2", 4'b0011, 1'b0, 1'b1);

        // R6 latch holds, other pair reset does not clear it
        ilim_i = 4'b0000;
        settle();
        check_out("R6", 4'b0011, 1'b0, 1'b1);
        pulse_cd();
        check_out("R6", 4'b0011, 1'b0, 1'b1);
        rst_ab_n_i = 1'b0; settle();
        check_out("R12", 4'b0011, 1'b1, 1'b1);
        check("R13", "pd_en_o", {4'h0, pd_en_o}, 8'h03);
        rst_ab_n_i = 1'b1; settle();
        check_out("R6", 4'b0000, 1'b1, 1'b1);

        // R5 direct trip on pair C/D
        olp_i = 2'b10; settle();
        check_out("R5", 4'b1100, 1'b0, 1'b1);
        olp_i = 2'b00; settle();
        check_out("R5", 4'b1100, 1'b0, 1'b1);
        pulse_cd();
        check_out("R6", 4'b0000, 1'b1, 1'b1);

        // R3 parallel mode spreads a pair overload to all four
        mode_i = 3'b011; settle();
        olp_i = 2'b01; settle();
        olp_i = 2'b00; settle();
        check_out("R3", 4'b1111, 1'b0, 1'b1);
        pulse_ab();
        check_out("R3", 4'b0000, 1'b1, 1'b1);
        mode_i = 3'b000; settle();

        // R10 warning with hysteresis
        temp_i = 8'd130; settle();
        check_out("R10", 4'b0000, 1'b1, 1'b0);
        temp_i = 8'd110; settle();
        check_out("R10", 4'b0000, 1'b1, 1'b0);
        temp_i = 8'd99; settle();
        check_out("R10", 4'b0000, 1'b1, 1'b1);

        // R9 overtemperature error latch and release rules
        temp_i = 8'd160; settle();
        check_out("R11", 4'b1111, 1'b0, 1'b0);
        temp_i = 8'd140; settle();
        rst_ab_n_i = 1'b0; settle();
        check_out("R12", 4'b1111, 1'b1, 1'b0);
        rst_ab_n_i = 1'b1; settle();
        check_out("R9", 4'b1111, 1'b0, 1'b0);
        rst_ab_n_i = 1'b0; rst_cd_n_i = 1'b0; settle();
        rst_ab_n_i = 1'b1; rst_cd_n_i = 1'b1; settle();
        check_out("R9", 4'b1111, 1'b0, 1'b0);
        temp_i = 8'd120; settle();
        rst_ab_n_i = 1'b0; rst_cd_n_i = 1'b0; settle();
        rst_ab_n_i = 1'b1; rst_cd_n_i = 1'b1; settle();
        check_out("R9", 4'b0000, 1'b1, 1'b0);
        temp_i = 8'd50; settle();
        check_out("R10", 4'b0000, 1'b1, 1'b1);

        // R14 power-on reset clears both kinds of latch
        olp_i = 2'b01; settle();
        olp_i = 2'b00;
        temp_i = 8'd170; settle();
        temp_i = 8'd50; settle();
        check_out("R14", 4'b1111, 1'b0, 1'b0);
        por_i = 1'b1; settle();
        check("R7", "hiz_o por", {4'h0, hiz_o}, 8'h0F);
        por_i = 1'b0; settle();
        check_out("R14", 4'b0000, 1'b1, 1'b1);

        done = 1'b1;
        finish_run();
    end
endmodule